// File: doc/BRIEF.md
# Direct-Mapped Block Cache with Miss Classifier

This block models the tag side of a small cache level. The level holds a few blocks taken from a larger backing store. Each incoming request carries a block number. The block number selects exactly one cache slot, which is the block number modulo the slot count. The block looks up that slot and answers hit or miss. On a miss it asks the backing level for the block, installs the block in the slot, and reports the block it displaced. No data is stored and no write policy is modelled.

Every miss is also sorted into one of three kinds:

- **Cold:** the block has not been requested since reset.
- **Conflict:** a fully associative directory of the same size, kept in least-recently-used order, would have held the block. The miss is therefore caused only by the fixed slot mapping.
- **Capacity:** even the associative directory had dropped the block, because the working set outgrew the cache.

One running counter per kind accumulates the misses. Performance tooling can read the counters to tell poor placement apart from a working set that is simply too large.

All outputs are registered. The response to a request presented at a rising edge is visible during the following cycle.

Top module: `blkcache_classifier`

## Requirements
- R1: A request for block b uses slot b mod NUM_SLOTS. It is a hit exactly when that slot is valid and holds b. rsp_valid and the result appear in the cycle after the request edge.
- R2: A miss raises fetch_valid for exactly that one response cycle, with fetch_blk equal to the requested block. A hit or an idle cycle leaves fetch_valid low.
- R3: On a miss into a valid slot, evict_valid is high and evict_blk gives the slot's previous occupant. A miss into an empty slot, and every hit, leave evict_valid low.
- R4: A miss on a block number not requested since reset is classified as cold.
- R5: Any other miss is classified as conflict when the block is among the NUM_SLOTS most recently requested distinct blocks. This is the content of an associative directory updated in least-recently-used order on every request.
- R6: Any remaining miss (seen before, absent from the associative directory) is classified as capacity.
- R7: Requests alternating between two blocks that share a slot miss on every access.
- R8: Each miss adds exactly one to the counter of its kind (cnt_cold, cnt_conflict, cnt_capacity). Hits and idle cycles change no counter.
- R9: A synchronous reset empties every slot, forgets all previously seen blocks, empties the associative directory, clears the counters, and leaves rsp_valid, fetch_valid and evict_valid low.
- R10: rsp_kind is encoded as 0 = hit, 1 = cold, 2 = conflict, 3 = capacity, and is 0 exactly when rsp_hit is high on a valid response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A block request is presented |
| req_blk | input | BLK_W | Requested block number |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Request hit in the cache |
| rsp_kind | output | 2 | 0 hit, 1 cold, 2 conflict, 3 capacity |
| fetch_valid | output | 1 | One-cycle fetch request to the backing level |
| fetch_blk | output | BLK_W | Block number to fetch |
| evict_valid | output | 1 | A valid occupant was displaced |
| evict_blk | output | BLK_W | Displaced block number |
| cnt_cold | output | CNT_W | Cold miss count |
| cnt_conflict | output | CNT_W | Conflict miss count |
| cnt_capacity | output | CNT_W | Capacity miss count |

## Verification
The bench targets these corner cases:

- **Ping-pong between blocks 0 and 8.** A design that mis-indexed slots would turn these misses into hits. A design that consulted a stale associative directory would classify them as capacity rather than conflict.
- **Second-touch misses after the associative directory has aged a block out.** These separate capacity from conflict. A design whose recency update was wrong (for example, not promoting on a hit) would swap the two labels.
- **First-touch misses into empty slots.** These expose a design that reports a spurious eviction.
- **Reset in the middle of a run.** This shows whether seen bits or counters leak across reset; a design that leaked them would label a repeat request as something other than cold.
- **Block number 255 at the top of the range.** This shows whether the first-touch map covers the whole block range.

// File: rtl/blkcache_pkg.sv
package blkcache_pkg;

    localparam int DEF_BLK_W     = 8;
    localparam int DEF_NUM_SLOTS = 4;
    localparam int DEF_CNT_W     = 16;

    typedef enum logic [1:0] {
        KIND_HIT      = 2'd0,
        KIND_COLD     = 2'd1,
        KIND_CONFLICT = 2'd2,
        KIND_CAPACITY = 2'd3
    } miss_kind_e;

    // Priority: hit, then first touch, then associative-shadow presence.
    function automatic miss_kind_e classify(input logic dm_hit,
                                            input logic first_touch,
                                            input logic shadow_hit);
        if (dm_hit)           return KIND_HIT;
        else if (first_touch) return KIND_COLD;
        else if (shadow_hit)  return KIND_CONFLICT;
        else                  return KIND_CAPACITY;
    endfunction

endpackage

// File: rtl/blk_seen_map.sv
module blk_seen_map #(
    parameter int BLK_W = blkcache_pkg::DEF_BLK_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [BLK_W-1:0] blk,
    output logic             first_touch
);
    localparam int NUM_BLKS = 1 << BLK_W;

    logic [NUM_BLKS-1:0] seen_q;

    assign first_touch = !seen_q[blk];

    always_ff @(posedge clk) begin
        if (rst)      seen_q <= '0;
        else if (upd) seen_q[blk] <= 1'b1;
    end
endmodule

// File: rtl/blk_slot_dir.sv
module blk_slot_dir #(
    parameter int BLK_W     = blkcache_pkg::DEF_BLK_W,
    parameter int NUM_SLOTS = blkcache_pkg::DEF_NUM_SLOTS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [BLK_W-1:0] blk,
    output logic             hit,
    output logic             occ_valid,
    output logic [BLK_W-1:0] occ_blk
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);

    logic [SLOT_W-1:0]          slot;
    logic [NUM_SLOTS-1:0]       vld_all;
    logic [NUM_SLOTS*BLK_W-1:0] tag_flat;

    assign slot      = blk[SLOT_W-1:0];
    assign occ_valid = vld_all[slot];
    assign occ_blk   = tag_flat[int'(slot)*BLK_W +: BLK_W];
    assign hit       = occ_valid && (occ_blk == blk);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic             v_q;
        logic [BLK_W-1:0] t_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                t_q <= '0;
            end else if (upd && !hit && slot == SLOT_W'(s)) begin
                v_q <= 1'b1;
                t_q <= blk;
            end
        end

        assign vld_all[s]                 = v_q;
        assign tag_flat[s*BLK_W +: BLK_W] = t_q;
    end
endmodule

// File: rtl/blk_lru_shadow.sv
module blk_lru_shadow #(
    parameter int BLK_W     = blkcache_pkg::DEF_BLK_W,
    parameter int NUM_SLOTS = blkcache_pkg::DEF_NUM_SLOTS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [BLK_W-1:0] blk,
    output logic             hit
);
    localparam int IDX_W = $clog2(NUM_SLOTS);

    // Position 0 is most recent, NUM_SLOTS-1 least recent.
    logic             ent_v   [NUM_SLOTS];
    logic [BLK_W-1:0] ent_b   [NUM_SLOTS];
    logic             nxt_v   [NUM_SLOTS];
    logic [BLK_W-1:0] nxt_b   [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] hit_vec;
    logic [IDX_W-1:0] hit_idx;

    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++)
            hit_vec[i] = ent_v[i] && (ent_b[i] == blk);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < NUM_SLOTS; i++)
            if (hit_vec[i]) hit_idx = IDX_W'(i);
    end

    // Move the referenced block to the front; entries ahead of it slide back.
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            nxt_v[i] = ent_v[i];
            nxt_b[i] = ent_b[i];
        end
        if (upd) begin
            for (int i = NUM_SLOTS - 1; i > 0; i--) begin
                if (!hit || IDX_W'(i) <= hit_idx) begin
                    nxt_v[i] = ent_v[i-1];
                    nxt_b[i] = ent_b[i-1];
                end
            end
            nxt_v[0] = 1'b1;
            nxt_b[0] = blk;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                ent_v[i] <= 1'b0;
                ent_b[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                ent_v[i] <= nxt_v[i];
                ent_b[i] <= nxt_b[i];
            end
        end
    end
endmodule

// File: rtl/blkcache_classifier.sv
module blkcache_classifier #(
    parameter int BLK_W     = blkcache_pkg::DEF_BLK_W,
    parameter int NUM_SLOTS = blkcache_pkg::DEF_NUM_SLOTS,
    parameter int CNT_W     = blkcache_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [BLK_W-1:0] req_blk,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [1:0]       rsp_kind,
    output logic             fetch_valid,
    output logic [BLK_W-1:0] fetch_blk,
    output logic             evict_valid,
    output logic [BLK_W-1:0] evict_blk,
    output logic [CNT_W-1:0] cnt_cold,
    output logic [CNT_W-1:0] cnt_conflict,
    output logic [CNT_W-1:0] cnt_capacity
);
    import blkcache_pkg::*;

    logic             dm_hit;
    logic             occ_valid;
    logic [BLK_W-1:0] occ_blk;
    logic             sh_hit;
    logic             first_touch;
    miss_kind_e       kind;

    blk_slot_dir #(.BLK_W(BLK_W), .NUM_SLOTS(NUM_SLOTS)) u_dir (
        .clk       (clk),
        .rst       (rst),
        .upd       (req_valid),
        .blk       (req_blk),
        .hit       (dm_hit),
        .occ_valid (occ_valid),
        .occ_blk   (occ_blk)
    );

    blk_lru_shadow #(.BLK_W(BLK_W), .NUM_SLOTS(NUM_SLOTS)) u_shadow (
        .clk (clk),
        .rst (rst),
        .upd (req_valid),
        .blk (req_blk),
        .hit (sh_hit)
    );

    blk_seen_map #(.BLK_W(BLK_W)) u_seen (
        .clk         (clk),
        .rst         (rst),
        .upd         (req_valid),
        .blk         (req_blk),
        .first_touch (first_touch)
    );

    assign kind = classify(dm_hit, first_touch, sh_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_kind     <= KIND_HIT;
            fetch_valid  <= 1'b0;
            fetch_blk    <= '0;
            evict_valid  <= 1'b0;
            evict_blk    <= '0;
            cnt_cold     <= '0;
            cnt_conflict <= '0;
            cnt_capacity <= '0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_hit     <= req_valid && dm_hit;
            rsp_kind    <= req_valid ? kind : KIND_HIT;
            fetch_valid <= req_valid && !dm_hit;
            fetch_blk   <= req_blk;
            evict_valid <= req_valid && !dm_hit && occ_valid;
            evict_blk   <= occ_blk;
            if (req_valid) begin
                unique case (kind)
                    KIND_COLD:     cnt_cold     <= cnt_cold + 1'b1;
                    KIND_CONFLICT: cnt_conflict <= cnt_conflict + 1'b1;
                    KIND_CAPACITY: cnt_capacity <= cnt_capacity + 1'b1;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/blkcache_classifier_chk.sv
module blkcache_classifier_chk #(
    parameter int BLK_W     = 8,
    parameter int NUM_SLOTS = 4,
    parameter int CNT_W     = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [BLK_W-1:0] req_blk,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [1:0]       rsp_kind,
    input logic             fetch_valid,
    input logic [BLK_W-1:0] fetch_blk,
    input logic             evict_valid,
    input logic [BLK_W-1:0] evict_blk,
    input logic [CNT_W-1:0] cnt_cold,
    input logic [CNT_W-1:0] cnt_conflict,
    input logic [CNT_W-1:0] cnt_capacity
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);

    p_fetch_on_miss_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (fetch_valid == !rsp_hit) && (fetch_blk == $past(req_blk)));

    p_no_fetch_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !fetch_valid && !rsp_valid);

    p_evict_only_miss_r3: assert property (@(posedge clk) disable iff (rst)
        evict_valid |-> rsp_valid && !rsp_hit && fetch_valid);

    p_evict_same_slot_r3: assert property (@(posedge clk) disable iff (rst)
        evict_valid |-> evict_blk[SLOT_W-1:0] == fetch_blk[SLOT_W-1:0]);

    p_kind_matches_hit_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit == (rsp_kind == 2'd0)));

    p_cold_step_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (cnt_cold == $past(cnt_cold) + CNT_W'(rsp_kind == 2'd1)));

    p_conflict_step_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (cnt_conflict == $past(cnt_conflict) + CNT_W'(rsp_kind == 2'd2)));

    p_capacity_step_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (cnt_capacity == $past(cnt_capacity) + CNT_W'(rsp_kind == 2'd3)));

    p_idle_counters_r8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(cnt_cold) && $stable(cnt_conflict) && $stable(cnt_capacity));
endmodule

bind blkcache_classifier blkcache_classifier_chk #(
    .BLK_W(BLK_W), .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_blk      (req_blk),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_kind     (rsp_kind),
    .fetch_valid  (fetch_valid),
    .fetch_blk    (fetch_blk),
    .evict_valid  (evict_valid),
    .evict_blk    (evict_blk),
    .cnt_cold     (cnt_cold),
    .cnt_conflict (cnt_conflict),
    .cnt_capacity (cnt_capacity)
);

// File: tb/blkcache_classifier_tb_top.sv
module blkcache_classifier_tb_top;
    localparam int BLK_W = 8;
    localparam int CNT_W = 16;
    localparam int NV    = 17;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [BLK_W-1:0] req_blk = '0;
    logic             rsp_valid, rsp_hit, fetch_valid, evict_valid;
    logic [1:0]       rsp_kind;
    logic [BLK_W-1:0] fetch_blk, evict_blk;
    logic [CNT_W-1:0] cnt_cold, cnt_conflict, cnt_capacity;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    blkcache_classifier #(.BLK_W(BLK_W), .NUM_SLOTS(4), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_blk(req_blk),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_kind(rsp_kind),
        .fetch_valid(fetch_valid), .fetch_blk(fetch_blk),
        .evict_valid(evict_valid), .evict_blk(evict_blk),
        .cnt_cold(cnt_cold), .cnt_conflict(cnt_conflict), .cnt_capacity(cnt_capacity)
    );

    // {block, hit, kind(0 hit,1 cold,2 conflict,3 capacity), evict valid, evict block}
    localparam logic [19:0] VEC [NV] = '{
        {8'd0, 1'b0, 2'd1, 1'b0, 8'd0},
        {8'd8, 1'b0, 2'd1, 1'b1, 8'd0},
        {8'd0, 1'b0, 2'd2, 1'b1, 8'd8},
        {8'd8, 1'b0, 2'd2, 1'b1, 8'd0},
        {8'd0, 1'b0, 2'd2, 1'b1, 8'd8},
        {8'd0, 1'b1, 2'd0, 1'b0, 8'd0},
        {8'd1, 1'b0, 2'd1, 1'b0, 8'd0},
        {8'd2, 1'b0, 2'd1, 1'b0, 8'd0},
        {8'd3, 1'b0, 2'd1, 1'b0, 8'd0},
        {8'd1, 1'b1, 2'd0, 1'b0, 8'd0},
        {8'd8, 1'b0, 2'd3, 1'b1, 8'd0},
        {8'd0, 1'b0, 2'd3, 1'b1, 8'd8},
        {8'd2, 1'b1, 2'd0, 1'b0, 8'd0},
        {8'd4, 1'b0, 2'd1, 1'b1, 8'd0},
        {8'd0, 1'b0, 2'd2, 1'b1, 8'd4},
        {8'd5, 1'b0, 2'd1, 1'b1, 8'd1},
        {8'd1, 1'b0, 2'd3, 1'b1, 8'd5}
    };

    task automatic chk(input string rid, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", rid, what, act, exp);
        end
    endtask

    // Drive at a falling edge; outputs for this request are stable at the next falling edge.
    task automatic apply(input logic v, input logic [BLK_W-1:0] b);
        req_valid = v;
        req_blk   = b;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic chk_cleared(input string rid);
        chk(rid, "rsp_valid",    int'(rsp_valid), 0);
        chk(rid, "fetch_valid",  int'(fetch_valid), 0);
        chk(rid, "evict_valid",  int'(evict_valid), 0);
        chk(rid, "cnt_cold",     int'(cnt_cold), 0);
        chk(rid, "cnt_conflict", int'(cnt_conflict), 0);
        chk(rid, "cnt_capacity", int'(cnt_capacity), 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ec, ef, ek;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk_cleared("R9");

        ec = 0; ef = 0; ek = 0;
        for (int i = 0; i < NV; i++) begin
            logic [BLK_W-1:0] b, eb;
            logic eh, ev;
            logic [1:0] kd;
            {b, eh, kd, ev, eb} = VEC[i];
            apply(1'b1, b);
            if (kd == 2'd1) ec++;
            if (kd == 2'd2) ef++;
            if (kd == 2'd3) ek++;
            chk("R1", "rsp_valid", int'(rsp_valid), 1);
            chk("R1", "rsp_hit", int'(rsp_hit), int'(eh));
            case (kd)
                2'd1: chk("R4", "kind cold", int'(rsp_kind), 1);
                2'd2: chk("R5", "kind conflict", int'(rsp_kind), 2);
                2'd3: chk("R6", "kind capacity", int'(rsp_kind), 3);
                default: chk("R10", "kind hit", int'(rsp_kind), 0);
            endcase
            chk("R2", "fetch_valid", int'(fetch_valid), int'(!eh));
            if (!eh) chk("R2", "fetch_blk", int'(fetch_blk), int'(b));
            chk("R3", "evict_valid", int'(evict_valid), int'(ev));
            if (ev) chk("R3", "evict_blk", int'(evict_blk), int'(eb));
            chk("R8", "cnt_cold", int'(cnt_cold), ec);
            chk("R8", "cnt_conflict", int'(cnt_conflict), ef);
            chk("R8", "cnt_capacity", int'(cnt_capacity), ek);
        end

        // Idle cycle: nothing fetched, counters hold (R8, R2).
        apply(1'b0, 8'd0);
        chk("R2", "idle fetch_valid", int'(fetch_valid), 0);
        chk("R8", "idle cnt_cold", int'(cnt_cold), 7);
        chk("R8", "idle cnt_conflict", int'(cnt_conflict), 4);
        chk("R8", "idle cnt_capacity", int'(cnt_capacity), 3);

        // Mid-run reset clears all state (R9).
        do_reset();
        chk_cleared("R9");
        apply(1'b1, 8'd0);
        chk("R9", "block 0 cold again", int'(rsp_kind), 1);
        chk("R9", "no evict after reset", int'(evict_valid), 0);

        // Ping-pong on one slot always misses (R7).
        for (int i = 0; i < 6; i++) begin
            apply(1'b1, (i % 2 == 0) ? 8'd8 : 8'd0);
            chk("R7", "ping-pong miss", int'(rsp_hit), 0);
        end

        // Top of block range (R4, R1, R3).
        do_reset();
        apply(1'b1, 8'd255);
        chk("R4", "block 255 cold", int'(rsp_kind), 1);
        chk("R3", "empty slot no evict", int'(evict_valid), 0);
        apply(1'b1, 8'd255);
        chk("R1", "block 255 hit", int'(rsp_hit), 1);
        apply(1'b1, 8'd3);
        chk("R4", "block 3 cold", int'(rsp_kind), 1);
        chk("R3", "evict 255", int'(evict_blk), 255);
        chk("R3", "evict valid", int'(evict_valid), 1);
        apply(1'b1, 8'd255);
        chk("R5", "255 conflict", int'(rsp_kind), 2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule